// File: doc/BRIEF.md
# Table-Lookup Waveform Generator

This block streams signed samples, one per clock, by reading a waveform held in an external read-only buffer with one cycle of read latency. Its four operating modes are off, calculated tone, one-shot playback and looped playback. The calculated tone walks a phase accumulator around a buffer that holds one sine period and scales each looked-up value by a gain word. The two playback modes send a chosen number of stored entries to the output as they are.

Settings arrive on plain configuration inputs: mode, frequency word, gain, start phase in degrees, and sample count. They are ignored until a one-cycle restart pulse copies them into an active set. That set then drives generation until the next restart. Each output sample carries a valid flag, a sync marker on the first sample of every period or pass, and an overflow flag that rises when the value had to be limited.

Top module: `wavegen_top`

## Requirements
- R1: While rst_n is low, out_val, out_sync, out_ovr and buf_rd_en are low and out_dat is zero.
- R2: Values on the cfg_* inputs have no effect until a cycle with restart high. The active settings, and so the output stream, keep their previous values until then.
- R3: In off mode (cfg_mode code 0), no buffer reads are issued, and out_val, out_sync and out_ovr stay low with out_dat zero.
- R4: In calc mode (code 1), a FREQ_W-bit accumulator is loaded on restart with floor(phase*2^FREQ_W/360) and grows by the frequency word every clock, modulo 2^FREQ_W. The buffer address is its top ADDR_W bits. The sample is floor(entry*gain/2^AMPL_FRAC). out_sync marks the first sample after restart and every sample read after the accumulator wrapped.
- R5: A frequency word of 2^FREQ_W equals the sample rate. It and its integer multiples give a constant output set by the phase. Half of it gives all zeros at phase 0, and at 90 degrees it gives +full scale and -full scale alternating.
- R6: A gain of 2^AMPL_FRAC reproduces the stored sine with no overflow. Any value beyond +/-(2^(DATA_W-1)-1) is limited to that bound, with out_ovr high on the same sample.
- R7: In single mode (code 2), exactly count entries are output from address 0 upward, with sync on the first one, and then output stops. A count of 0 outputs nothing. A count above the buffer depth is treated as the depth.
- R8: In repeat mode (code 3), addresses 0 to count-1 are output back to back without end, with sync on every address-0 sample.
- R9: The code -2^(DATA_W-1) never appears on out_dat. A stored entry with that code is output as -(2^(DATA_W-1)-1) with out_ovr high.
- R10: A read issued in one cycle produces its valid sample in the next cycle. Restart discards the sample that is in flight, so out_val is low in the cycle after restart.
- R11: out_sync is only ever high together with out_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | One-cycle pulse that applies the cfg_* settings |
| cfg_mode | input | 2 | Mode: 0 off, 1 calc, 2 single, 3 repeat |
| cfg_freq | input | FWORD_W | Phase step per clock; 2^FREQ_W equals the sample rate |
| cfg_ampl | input | AMPL_W | Gain, unity at 2^AMPL_FRAC |
| cfg_phase | input | PHASE_W | Start phase in degrees |
| cfg_count | input | CNT_W | Number of entries for single and repeat |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_addr | output | ADDR_W | Buffer read address |
| buf_rd_data | input | DATA_W | Buffer data, one cycle after the request |
| out_dat | output | DATA_W | Signed output sample |
| out_val | output | 1 | Sample valid |
| out_sync | output | 1 | First sample of a period or pass |
| out_ovr | output | 1 | Sample was limited |

## Verification
Restart can arrive in the same cycle as an ongoing sequence event, such as the final read of a one-shot pass, an accumulator wrap or a loop return. In that case the new settings and the flush must win over the sequencer's own step. The bench times a restart to land exactly on the last read of a three-entry single pass. It expects a low out_val in the next cycle and then a sync-marked first sample of the new looped pass. A behavioural model that applies restart before any sequence step checks every cycle of these collisions.

// File: rtl/wavegen_pkg.sv
`timescale 1ns/1ps
package wavegen_pkg;
  typedef enum logic [1:0] {
    WG_OFF    = 2'd0,
    WG_CALC   = 2'd1,
    WG_SINGLE = 2'd2,
    WG_REPEAT = 2'd3
  } wg_mode_e;
endpackage

// File: rtl/wavegen_cfg.sv
`timescale 1ns/1ps
// Active settings register: copies the configuration only on restart.
module wavegen_cfg
  import wavegen_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int FWORD_W = 18,
  parameter int AMPL_W  = 10,
  parameter int CNT_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [1:0]         cfg_mode,
  input  logic [FWORD_W-1:0] cfg_freq,
  input  logic [AMPL_W-1:0]  cfg_ampl,
  input  logic [CNT_W-1:0]   cfg_count,
  output wg_mode_e           act_mode,
  output logic [FWORD_W-1:0] act_freq,
  output logic [AMPL_W-1:0]  act_ampl,
  output logic [CNT_W-1:0]   act_cnt
);
  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1 << ADDR_W);

  // count limited to the buffer depth
  function automatic logic [CNT_W-1:0] fit_count(input logic [CNT_W-1:0] c);
    return (c > DEPTH) ? DEPTH : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode <= WG_OFF;
      act_freq <= '0;
      act_ampl <= '0;
      act_cnt  <= '0;
    end else if (restart) begin
      act_mode <= wg_mode_e'(cfg_mode);
      act_freq <= cfg_freq;
      act_ampl <= cfg_ampl;
      act_cnt  <= fit_count(cfg_count);
    end
  end
endmodule

// File: rtl/wavegen_seq.sv
`timescale 1ns/1ps
// Address sequencer: phase accumulator for calc, index counter for playback.
module wavegen_seq
  import wavegen_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int FREQ_W  = 16,
  parameter int FWORD_W = 18,
  parameter int PHASE_W = 9,
  parameter int CNT_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [1:0]         cfg_mode,
  input  logic [PHASE_W-1:0] cfg_phase,
  input  logic [CNT_W-1:0]   cfg_count,
  input  wg_mode_e           act_mode,
  input  logic [FWORD_W-1:0] act_freq,
  input  logic [CNT_W-1:0]   act_cnt,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               issue_sync,
  output logic               issue_calc
);
  localparam int SUM_W = FWORD_W + 1;
  localparam int DEG_W = PHASE_W + FREQ_W;

  // degrees to accumulator units: floor(deg * 2^FREQ_W / 360)
  function automatic logic [FREQ_W-1:0] deg_to_acc(input logic [PHASE_W-1:0] deg);
    logic [DEG_W-1:0] scaled;
    scaled = {deg, {FREQ_W{1'b0}}};
    return FREQ_W'(scaled / DEG_W'(360));
  endfunction

  logic [FREQ_W-1:0] acc_q;
  logic              wrap_q;
  logic              first_q;
  logic [ADDR_W-1:0] idx_q;
  logic              run_q;

  logic [SUM_W-1:0]  acc_sum;
  logic              acc_wrap;
  logic [CNT_W-1:0]  idx_inc;
  logic              pass_end;
  logic              start_ok;
  logic              mode_calc;

  assign mode_calc = (act_mode == WG_CALC);
  assign acc_sum   = SUM_W'(acc_q) + SUM_W'(act_freq);
  assign acc_wrap  = |acc_sum[SUM_W-1:FREQ_W];
  assign idx_inc   = CNT_W'(idx_q) + CNT_W'(1);
  assign pass_end  = (idx_inc == act_cnt);
  assign start_ok  = (cfg_mode == WG_CALC) ||
                     ((cfg_mode != WG_OFF) && (cfg_count != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      wrap_q  <= 1'b0;
      first_q <= 1'b0;
      idx_q   <= '0;
      run_q   <= 1'b0;
    end else if (restart) begin
      acc_q   <= deg_to_acc(cfg_phase);
      wrap_q  <= 1'b0;
      first_q <= 1'b1;
      idx_q   <= '0;
      run_q   <= start_ok;
    end else if (run_q) begin
      first_q <= 1'b0;
      if (mode_calc) begin
        acc_q  <= acc_sum[FREQ_W-1:0];
        wrap_q <= acc_wrap;
      end else if (pass_end) begin
        idx_q <= '0;
        if (act_mode == WG_SINGLE) run_q <= 1'b0;
      end else begin
        idx_q <= idx_inc[ADDR_W-1:0];
      end
    end
  end

  assign rd_en      = run_q;
  assign rd_addr    = mode_calc ? acc_q[FREQ_W-1 -: ADDR_W] : idx_q;
  assign issue_sync = mode_calc ? (first_q | wrap_q) : (idx_q == '0);
  assign issue_calc = mode_calc;
endmodule

// File: rtl/wavegen_shape.sv
`timescale 1ns/1ps
// Output stage: tracks the in-flight read, applies gain, limits symmetrically.
module wavegen_shape #(
  parameter int DATA_W    = 12,
  parameter int AMPL_W    = 10,
  parameter int AMPL_FRAC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              rd_en,
  input  logic              issue_sync,
  input  logic              issue_calc,
  input  logic [AMPL_W-1:0] act_ampl,
  input  logic [DATA_W-1:0] buf_rd_data,
  output logic [DATA_W-1:0] out_dat,
  output logic              out_val,
  output logic              out_sync,
  output logic              out_ovr
);
  localparam int PROD_W = DATA_W + AMPL_W + 1;
  localparam int MAXV   = (1 << (DATA_W - 1)) - 1;
  localparam logic signed [PROD_W-1:0] POS_LIM = PROD_W'(MAXV);
  localparam logic signed [PROD_W-1:0] NEG_LIM = -POS_LIM;

  function automatic logic signed [PROD_W-1:0] widen(input logic [DATA_W-1:0] smp);
    return $signed({{(PROD_W-DATA_W){smp[DATA_W-1]}}, smp});
  endfunction

  // floor(sample * gain / 2^AMPL_FRAC)
  function automatic logic signed [PROD_W-1:0] apply_gain(
    input logic [DATA_W-1:0] smp, input logic [AMPL_W-1:0] g);
    logic signed [PROD_W-1:0] gw;
    logic signed [PROD_W-1:0] prod;
    gw   = $signed({{(PROD_W-AMPL_W){1'b0}}, g});
    prod = widen(smp) * gw;
    return prod >>> AMPL_FRAC;
  endfunction

  // {overflow, limited sample}
  function automatic logic [DATA_W:0] limit(input logic signed [PROD_W-1:0] v);
    if (v > POS_LIM)      return {1'b1, POS_LIM[DATA_W-1:0]};
    else if (v < NEG_LIM) return {1'b1, NEG_LIM[DATA_W-1:0]};
    else                  return {1'b0, v[DATA_W-1:0]};
  endfunction

  logic v_q, s_q, c_q;
  logic signed [PROD_W-1:0] raw;
  logic [DATA_W:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      s_q <= 1'b0;
      c_q <= 1'b0;
    end else if (restart) begin
      v_q <= 1'b0;
      s_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      v_q <= rd_en;
      s_q <= rd_en & issue_sync;
      c_q <= issue_calc;
    end
  end

  always_comb begin
    raw = c_q ? apply_gain(buf_rd_data, act_ampl) : widen(buf_rd_data);
    lim = limit(raw);
  end

  assign out_val  = v_q;
  assign out_sync = s_q;
  assign out_dat  = v_q ? lim[DATA_W-1:0] : '0;
  assign out_ovr  = v_q & lim[DATA_W];
endmodule

// File: rtl/wavegen_top.sv
`timescale 1ns/1ps
module wavegen_top
  import wavegen_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 12,
  parameter int FREQ_W    = 16,
  parameter int AMPL_FRAC = 8,
  parameter int GAIN_W    = 2,
  parameter int PHASE_W   = 9,
  localparam int FWORD_W  = FREQ_W + 2,
  localparam int AMPL_W   = AMPL_FRAC + GAIN_W,
  localparam int CNT_W    = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [1:0]         cfg_mode,
  input  logic [FWORD_W-1:0] cfg_freq,
  input  logic [AMPL_W-1:0]  cfg_ampl,
  input  logic [PHASE_W-1:0] cfg_phase,
  input  logic [CNT_W-1:0]   cfg_count,
  output logic               buf_rd_en,
  output logic [ADDR_W-1:0]  buf_rd_addr,
  input  logic [DATA_W-1:0]  buf_rd_data,
  output logic [DATA_W-1:0]  out_dat,
  output logic               out_val,
  output logic               out_sync,
  output logic               out_ovr
);
  wg_mode_e           act_mode;
  logic [FWORD_W-1:0] act_freq;
  logic [AMPL_W-1:0]  act_ampl;
  logic [CNT_W-1:0]   act_cnt;
  logic               issue_sync;
  logic               issue_calc;

  wavegen_cfg #(
    .ADDR_W(ADDR_W), .FWORD_W(FWORD_W), .AMPL_W(AMPL_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .cfg_mode(cfg_mode), .cfg_freq(cfg_freq), .cfg_ampl(cfg_ampl),
    .cfg_count(cfg_count),
    .act_mode(act_mode), .act_freq(act_freq), .act_ampl(act_ampl),
    .act_cnt(act_cnt)
  );

  wavegen_seq #(
    .ADDR_W(ADDR_W), .FREQ_W(FREQ_W), .FWORD_W(FWORD_W),
    .PHASE_W(PHASE_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .cfg_mode(cfg_mode), .cfg_phase(cfg_phase), .cfg_count(cfg_count),
    .act_mode(act_mode), .act_freq(act_freq), .act_cnt(act_cnt),
    .rd_en(buf_rd_en), .rd_addr(buf_rd_addr),
    .issue_sync(issue_sync), .issue_calc(issue_calc)
  );

  wavegen_shape #(
    .DATA_W(DATA_W), .AMPL_W(AMPL_W), .AMPL_FRAC(AMPL_FRAC)
  ) u_shape (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .rd_en(buf_rd_en), .issue_sync(issue_sync), .issue_calc(issue_calc),
    .act_ampl(act_ampl), .buf_rd_data(buf_rd_data),
    .out_dat(out_dat), .out_val(out_val), .out_sync(out_sync),
    .out_ovr(out_ovr)
  );
endmodule

// File: rtl/wavegen_chk.sv
`timescale 1ns/1ps
module wavegen_chk #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              rd_en,
  input logic              out_val,
  input logic              out_sync,
  input logic              out_ovr,
  input logic [DATA_W-1:0] out_dat,
  input logic [1:0]        act_mode,
  input logic [CNT_W-1:0]  act_cnt
);
  localparam logic [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] POS_FS   = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_FS   = {1'b1, {(DATA_W-2){1'b0}}, 1'b1};

  // R11
  sync_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |-> out_val);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_val |-> (out_dat == '0 && !out_sync && !out_ovr));

  // R3
  off_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'd0) |-> !rd_en);

  // R10
  read_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !restart) |=> out_val);

  // R10
  restart_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out_val);

  // R2
  hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ($stable(act_mode) && $stable(act_cnt)));

  // R9
  no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_dat != MIN_CODE);

  // R6
  ovr_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovr |-> (out_dat == POS_FS || out_dat == NEG_FS));
endmodule

bind wavegen_top wavegen_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .rd_en(buf_rd_en),
  .out_val(out_val), .out_sync(out_sync), .out_ovr(out_ovr),
  .out_dat(out_dat), .act_mode(act_mode), .act_cnt(act_cnt)
);

// File: tb/wavegen_top_bench.sv
`timescale 1ns/1ps
module wavegen_top_bench;
  localparam int ADDR_W = 6, DATA_W = 12, FREQ_W = 16, AMPL_FRAC = 8;
  localparam int GAIN_W = 2, PHASE_W = 9;
  localparam int FWORD_W = FREQ_W + 2, AMPL_W = AMPL_FRAC + GAIN_W, CNT_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ACC_SIZE = 1 << FREQ_W;
  localparam int MAXV = (1 << (DATA_W - 1)) - 1;
  localparam int UNITY = 1 << AMPL_FRAC;

  logic clk = 0, rst_n = 0, restart = 0;
  logic [1:0] cfg_mode = 0;
  logic [FWORD_W-1:0] cfg_freq = 0;
  logic [AMPL_W-1:0] cfg_ampl = 0;
  logic [PHASE_W-1:0] cfg_phase = 0;
  logic [CNT_W-1:0] cfg_count = 0;
  logic buf_rd_en;
  logic [ADDR_W-1:0] buf_rd_addr;
  logic [DATA_W-1:0] buf_rd_data;
  logic signed [DATA_W-1:0] out_dat;
  logic out_val, out_sync, out_ovr;

  logic signed [DATA_W-1:0] mem [0:DEPTH-1];

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wavegen_top u_wavegen_top (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .cfg_mode(cfg_mode), .cfg_freq(cfg_freq), .cfg_ampl(cfg_ampl),
    .cfg_phase(cfg_phase), .cfg_count(cfg_count),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .out_dat(out_dat), .out_val(out_val), .out_sync(out_sync), .out_ovr(out_ovr)
  );

  // buffer model, one cycle of read latency
  always @(posedge clk) if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mode = 0, m_freq = 0, m_ampl = 0, m_cnt = 0, m_acc = 0, m_idx = 0;
  bit m_run = 0, m_first = 0, m_wrap = 0;
  bit e_val = 0, e_sync = 0, e_ovr = 0;
  int e_dat = 0;

  always @(posedge clk) begin
    int a, raw, nxt;
    bit sy;
    if (!rst_n) begin
      m_run = 0; m_mode = 0; e_val = 0; e_sync = 0; e_ovr = 0; e_dat = 0;
    end else if (restart) begin
      e_val = 0; e_sync = 0; e_ovr = 0; e_dat = 0;
      m_mode = cfg_mode; m_freq = cfg_freq; m_ampl = cfg_ampl;
      m_cnt = (cfg_count > DEPTH) ? DEPTH : cfg_count;
      m_acc = (int'(cfg_phase) * ACC_SIZE / 360) % ACC_SIZE;
      m_idx = 0; m_first = 1; m_wrap = 0;
      m_run = (m_mode == 1) || (m_mode >= 2 && m_cnt > 0);
    end else if (m_run) begin
      if (m_mode == 1) begin
        a = m_acc / (ACC_SIZE / DEPTH);
        sy = m_first || m_wrap;
        raw = (int'(mem[a]) * m_ampl) >>> AMPL_FRAC;
        nxt = m_acc + m_freq;
        m_wrap = (nxt >= ACC_SIZE);
        m_acc = nxt % ACC_SIZE;
      end else begin
        a = m_idx;
        sy = (m_idx == 0);
        raw = int'(mem[a]);
        if (m_idx == m_cnt - 1) begin
          m_idx = 0;
          if (m_mode == 2) m_run = 0;
        end else m_idx++;
      end
      m_first = 0;
      e_ovr = (raw > MAXV) || (raw < -MAXV);
      e_dat = (raw > MAXV) ? MAXV : (raw < -MAXV) ? -MAXV : raw;
      e_val = 1; e_sync = sy;
    end else begin
      e_val = 0; e_sync = 0; e_ovr = 0; e_dat = 0;
    end
  end

  function automatic string mode_tag();
    if (!rst_n) return "R1";
    case (m_mode)
      1: return "R4";
      2: return "R7";
      3: return "R8";
      default: return "R3";
    endcase
  endfunction

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (!done) begin
    check({mode_tag(), " val"},  out_val == e_val,   out_val,  e_val);
    check({mode_tag(), " sync"}, out_sync == e_sync, out_sync, e_sync);
    check({mode_tag(), " ovr"},  out_ovr == e_ovr,   out_ovr,  e_ovr);
    check({mode_tag(), " dat"},  int'(out_dat) == e_dat, out_dat, e_dat);
  end

  // ---------------- stimulus helpers ----------------
  int o_val, o_sync, o_ovr, o_rd, o_min, o_max;

  task automatic observe(input int cycles);
    o_val = 0; o_sync = 0; o_ovr = 0; o_rd = 0; o_min = 1 << 30; o_max = -(1 << 30);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (buf_rd_en) o_rd++;
      if (out_val) begin
        o_val++;
        if (int'(out_dat) < o_min) o_min = out_dat;
        if (int'(out_dat) > o_max) o_max = out_dat;
      end
      if (out_sync) o_sync++;
      if (out_ovr) o_ovr++;
    end
  endtask

  task automatic do_restart(input int md, input int fq, input int am, input int ph, input int ct);
    @(negedge clk);
    cfg_mode = 2'(md); cfg_freq = FWORD_W'(fq); cfg_ampl = AMPL_W'(am);
    cfg_phase = PHASE_W'(ph); cfg_count = CNT_W'(ct);
    restart = 1;
    @(negedge clk);
    restart = 0;
    check("R10 flush", out_val == 0, out_val, 0);
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++)
      mem[k] = DATA_W'($rtoi($floor(MAXV * $sin(2.0 * 3.14159265358979 * k / DEPTH) + 0.5)));

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 val", out_val == 0, out_val, 0);
    check("R1 rd_en", buf_rd_en == 0, buf_rd_en, 0);
    check("R1 dat", out_dat == 0, out_dat, 0);
    rst_n = 1;

    // R2: settings without restart are ignored
    cfg_mode = 2'd1; cfg_freq = FWORD_W'(4096); cfg_ampl = AMPL_W'(UNITY);
    observe(20);
    check("R2 no output before restart", o_val == 0, o_val, 0);
    check("R2 no reads before restart", o_rd == 0, o_rd, 0);

    // R4: calc at Fs/16, unity gain
    do_restart(1, 4096, UNITY, 0, 0);
    @(negedge clk);
    check("R4 first sync", out_sync == 1, out_sync, 1);
    check("R4 first dat", int'(out_dat) == int'(mem[0]), out_dat, mem[0]);
    @(negedge clk);
    check("R4 second dat", int'(out_dat) == int'(mem[4]), out_dat, mem[4]);
    cfg_mode = 2'd0; cfg_freq = FWORD_W'(1234);   // R2: no restart follows
    observe(64);
    check("R2 stream continues", o_val == 64, o_val, 64);
    check("R4 syncs per 64", o_sync == 4, o_sync, 4);
    check("R6 unity gain no ovr", o_ovr == 0, o_ovr, 0);

    // R5: Fs/2 at phase 0 is silent, at 90 degrees alternates
    do_restart(1, ACC_SIZE / 2, UNITY, 0, 0);
    observe(16);
    check("R5 half rate zero max", o_max == 0, o_max, 0);
    check("R5 half rate zero min", o_min == 0, o_min, 0);
    do_restart(1, ACC_SIZE / 2, UNITY, 90, 0);
    @(negedge clk);
    check("R5 cosine +", int'(out_dat) == MAXV, out_dat, MAXV);
    @(negedge clk);
    check("R5 cosine -", int'(out_dat) == -MAXV, out_dat, -MAXV);

    // R5: DC at Fs and 2*Fs, level set by phase 45 -> address 8
    do_restart(1, ACC_SIZE, UNITY, 45, 0);
    observe(20);
    check("R5 dc min", o_min == int'(mem[8]), o_min, mem[8]);
    check("R5 dc max", o_max == int'(mem[8]), o_max, mem[8]);
    do_restart(1, 2 * ACC_SIZE, UNITY, 45, 0);
    observe(20);
    check("R5 dc 2Fs", o_min == o_max && o_max == int'(mem[8]), o_max, mem[8]);

    // R6: gain of three clips
    do_restart(1, 4096, 3 * UNITY, 0, 0);
    observe(64);
    check("R6 ovr seen", o_ovr > 0, o_ovr, 1);
    check("R6 pos limit", o_max == MAXV, o_max, MAXV);
    check("R6 neg limit", o_min == -MAXV, o_min, -MAXV);

    // R3: off
    do_restart(0, 4096, UNITY, 0, 10);
    observe(30);
    check("R3 off no valid", o_val == 0, o_val, 0);
    check("R3 off no reads", o_rd == 0, o_rd, 0);

    // R7: single
    do_restart(2, 0, 0, 0, 10);
    observe(40);
    check("R7 single count", o_val == 10, o_val, 10);
    check("R7 single sync", o_sync == 1, o_sync, 1);
    do_restart(2, 0, 0, 0, 100);
    observe(100);
    check("R7 count above depth", o_val == DEPTH, o_val, DEPTH);
    do_restart(2, 0, 0, 0, 0);
    observe(10);
    check("R7 zero count", o_val == 0, o_val, 0);

    // R8: repeat
    do_restart(3, 0, 0, 0, 5);
    observe(50);
    check("R8 repeat valid", o_val == 50, o_val, 50);
    check("R8 repeat syncs", o_sync == 10, o_sync, 10);

    // R9: most negative stored code
    @(negedge clk);
    mem[2] = {1'b1, {(DATA_W-1){1'b0}}};
    do_restart(2, 0, 0, 0, 4);
    repeat (3) @(negedge clk);
    check("R9 min code limited", int'(out_dat) == -MAXV, out_dat, -MAXV);
    check("R9 min code ovr", out_ovr == 1, out_ovr, 1);
    repeat (4) @(negedge clk);
    mem[2] = DATA_W'($rtoi($floor(MAXV * $sin(2.0 * 3.14159265358979 * 2 / DEPTH) + 0.5)));

    // R10: restart on the last read of a single pass
    do_restart(2, 0, 0, 0, 3);
    @(negedge clk);
    do_restart(3, 0, 0, 0, 2);
    @(negedge clk);
    check("R8 new pass sync", out_sync == 1, out_sync, 1);
    observe(20);

    do_restart(0, 0, 0, 0, 0);
    observe(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule